// File: doc/BRIEF.md
# Shared-Memory Atomic Update Engine

This block sits between several requesting agents (two by default) and one single-port memory, and it owns that memory. Each agent sends one request at a time. A request can be a load, a store, an increment, or a compare-exchange on a naturally sized operand of 1, 2, 4 or 8 bytes. The operand sits inside a 64-bit memory line. The lowest three bits of the byte address select its lane, and byte enables write only the lanes it covers. A byte access therefore takes exactly as many cycles as a full-line access.

Increments and compare-exchanges come in two forms, selected by a lock flag.

- **Unlocked:** the operation runs as three separate memory steps. The engine reads into a per-agent temporary, modifies the temporary in a later cycle, and writes it back through a new arbitration round. Other agents may use the memory between the read and the write, so a concurrent update can be lost.
- **Locked:** the memory is read and then written, or skipped on a compare miss, in the very next cycle. No other agent gets the port between the two.

The memory has a one-cycle read latency. Agents take turns through round-robin arbitration.

Back-pressure on both sides of an agent follows valid/ready rules:

- A request is taken on a clock edge where both `req_valid` and `req_ready` are high. `req_ready` is high only while the agent has no operation in flight.
- A response stays on `rsp_valid` with unchanged data until the clock edge where `rsp_ready` is also high. Only after that can the agent accept its next request.

Top module: `amo_rmw_unit`

## Requirements
- R1: After reset every agent shows `req_ready`=1 and `rsp_valid`=0.
- R2: The opcode is 0=load, 1=store, 2=increment, 3=compare-exchange. A load returns the operand zero-extended and right-aligned, with `rsp_ok`=1. Size code s (0..3) means 2^s bytes starting at byte address `addr`, in lane `addr[2:0]` of line `addr[ADDR_W-1:3]`.
- R3: A store writes only the addressed bytes and leaves every other byte of the line unchanged. It responds with data 0 and `rsp_ok`=1.
- R4: An unlocked increment returns the old operand and stores old+1, wrapping within the operand size. Its read and write are separate grants. When two agents start unlocked increments on the same operand in the same cycle, both receive the same old value and memory ends at old+1.
- R5: When the read of a locked operation is granted, the following cycle's grant goes to the same agent. Two agents doing locked increments together therefore leave old+2, and they receive old and old+1.
- R6: A compare-exchange compares the masked expected value with the operand. On a match it stores the new value and responds `rsp_ok`=1. On a mismatch memory is unchanged and it responds `rsp_ok`=0. In both cases the response data is the operand value read.
- R7: If the address is not a multiple of the operand size, the engine responds `rsp_err`=1, `rsp_ok`=0 and data 0, and memory is left unchanged.
- R8: At most one agent holds the memory grant per cycle, and only an agent that asks for it. Among agents that ask together, priority rotates to the agent after the last one granted, starting with agent 0 after reset. A locked operation's write cycle does not move the rotation.
- R9: A pending response keeps `rsp_valid` high with stable data while `rsp_ready` is low. Each agent has at most one operation outstanding.
- R10: The lock flag has no effect on loads and stores.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | N_REQ | Request valid, one bit per agent |
| req_ready | output | N_REQ | Request ready, one bit per agent |
| req_op | input | 2*N_REQ | Opcode per agent |
| req_size | input | 2*N_REQ | Size code per agent (2^s bytes) |
| req_lock | input | N_REQ | Lock flag per agent |
| req_addr | input | ADDR_W*N_REQ | Byte address per agent |
| req_wdata | input | 64*N_REQ | Store value or new value for compare-exchange |
| req_cmp | input | 64*N_REQ | Expected value for compare-exchange |
| rsp_valid | output | N_REQ | Response valid per agent |
| rsp_ready | input | N_REQ | Response ready per agent |
| rsp_data | output | 64*N_REQ | Load value or old operand value |
| rsp_ok | output | N_REQ | Success flag |
| rsp_err | output | N_REQ | Misalignment error flag |

## Verification
The hardest state to reach from the ports is two agents in the window between a read and its write on the same operand. In that window an unlocked update can be lost, and a locked one must be serialised. The bench reaches it by starting two requests on the same falling edge, so both are accepted on one clock edge and contend for the port in the same cycle. It resets the engine before one such race, and issues a single-agent operation before another, so the rotation state is known and the winner's response can be predicted exactly. Random single-agent traffic over all sizes, lanes and opcodes is checked against a byte-level reference model.

// File: rtl/amo_pkg.sv
package amo_pkg;
  localparam int LINE_W = 64;
  localparam int LANES  = LINE_W / 8;
  localparam int OFF_W  = $clog2(LANES);

  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_STORE = 2'd1,
    OP_INC   = 2'd2,
    OP_CAS   = 2'd3
  } amo_op_e;

  typedef enum logic [2:0] {
    S_IDLE, S_RD, S_LD, S_OP, S_WR, S_LWR, S_RSP
  } agent_st_e;

  function automatic logic [LINE_W-1:0] size_mask(input logic [1:0] sz);
    if (sz == 2'd3) return '1;
    return (LINE_W'(1) << (8 << sz)) - LINE_W'(1);
  endfunction

  function automatic logic misaligned(input logic [OFF_W-1:0] off, input logic [1:0] sz);
    return (int'(off) % (1 << sz)) != 0;
  endfunction

  function automatic logic [LINE_W-1:0] lane_get(input logic [LINE_W-1:0] line,
                                                 input logic [OFF_W-1:0] off,
                                                 input logic [1:0] sz);
    return (line >> {off, 3'b000}) & size_mask(sz);
  endfunction

  function automatic logic [LINE_W-1:0] lane_put(input logic [LINE_W-1:0] val,
                                                 input logic [OFF_W-1:0] off);
    return val << {off, 3'b000};
  endfunction

  function automatic logic [LANES-1:0] lane_be(input logic [OFF_W-1:0] off, input logic [1:0] sz);
    logic [LANES-1:0] m;
    m = LANES'((1 << (1 << sz)) - 1);
    return m << off;
  endfunction
endpackage

// File: rtl/amo_mem.sv
module amo_mem import amo_pkg::*; #(
  parameter int IDX_W = 4,
  localparam int WORDS = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              en,
  input  logic              we,
  input  logic [IDX_W-1:0]  idx,
  input  logic [LINE_W-1:0] wline,
  input  logic [LANES-1:0]  be,
  output logic [LINE_W-1:0] rdata
);
  logic [LINE_W-1:0] store_q [WORDS];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) begin
        for (int b = 0; b < LANES; b++)
          if (be[b]) store_q[idx][b*8 +: 8] <= wline[b*8 +: 8];
      end else begin
        rdata <= store_q[idx];
      end
    end
  end
endmodule

// File: rtl/amo_arb.sv
module amo_arb #(
  parameter int N = 2,
  localparam int PW = (N > 1) ? $clog2(N) : 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  input  logic [N-1:0] hold,
  output logic [N-1:0] gnt
);
  logic [PW-1:0] ptr, nxt;
  logic          found;
  int            j;

  always_comb begin
    gnt   = '0;
    nxt   = ptr;
    found = 1'b0;
    j     = 0;
    if (|hold) begin
      for (int i = 0; i < N; i++)
        if (hold[i] && !found) begin
          gnt[i] = 1'b1;
          found  = 1'b1;
        end
    end else begin
      for (int k = 0; k < N; k++) begin
        j = (int'(ptr) + k) % N;
        if (req[j] && !found) begin
          gnt[j] = 1'b1;
          found  = 1'b1;
          nxt    = PW'((j + 1) % N);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ptr <= '0;
    else        ptr <= nxt;
  end
endmodule

// File: rtl/amo_agent.sv
module amo_agent import amo_pkg::*; #(
  parameter int ADDR_W = 7,
  localparam int IDX_W = ADDR_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [1:0]        req_size,
  input  logic              req_lock,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LINE_W-1:0] req_wdata,
  input  logic [LINE_W-1:0] req_cmp,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [LINE_W-1:0] rsp_data,
  output logic              rsp_ok,
  output logic              rsp_err,
  output logic              mem_req,
  output logic              mem_hold,
  output logic              mem_lockrd,
  input  logic              mem_gnt,
  output logic              mem_we,
  output logic [IDX_W-1:0]  mem_idx,
  output logic [LINE_W-1:0] mem_wline,
  output logic [LANES-1:0]  mem_be,
  input  logic [LINE_W-1:0] mem_rdata
);
  agent_st_e         st;
  amo_op_e           op;
  logic [1:0]        sz;
  logic              lk;
  logic [OFF_W-1:0]  off;
  logic [LINE_W-1:0] wval, cmpv, tmp;

  logic              locked, cas_hit, need_wr;
  logic [LINE_W-1:0] mask, old_lwr, base, newv;

  always_comb begin
    locked  = lk && (op == OP_INC || op == OP_CAS);
    mask    = size_mask(sz);
    old_lwr = lane_get(mem_rdata, off, sz);
    base    = (st == S_LWR) ? old_lwr : tmp;
    cas_hit = (base == (cmpv & mask));
    newv    = (op == OP_INC) ? ((base + LINE_W'(1)) & mask) : wval;
    need_wr = (op == OP_INC) || cas_hit;
  end

  assign req_ready  = (st == S_IDLE);
  assign rsp_valid  = (st == S_RSP);
  assign mem_req    = (st == S_RD) || (st == S_WR) || (st == S_LWR);
  assign mem_hold   = (st == S_LWR);
  assign mem_lockrd = (st == S_RD) && locked;
  assign mem_we     = (st == S_WR) || ((st == S_LWR) && need_wr);
  assign mem_wline  = lane_put((st == S_WR) ? wval : newv, off);
  assign mem_be     = lane_be(off, sz);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      op       <= OP_LOAD;
      sz       <= '0;
      lk       <= 1'b0;
      off      <= '0;
      mem_idx  <= '0;
      wval     <= '0;
      cmpv     <= '0;
      tmp      <= '0;
      rsp_data <= '0;
      rsp_ok   <= 1'b0;
      rsp_err  <= 1'b0;
    end else begin
      unique case (st)
        S_IDLE: if (req_valid) begin
          op       <= amo_op_e'(req_op);
          sz       <= req_size;
          lk       <= req_lock;
          off      <= req_addr[OFF_W-1:0];
          mem_idx  <= req_addr[ADDR_W-1:OFF_W];
          wval     <= req_wdata & size_mask(req_size);
          cmpv     <= req_cmp;
          rsp_data <= '0;
          rsp_ok   <= 1'b1;
          rsp_err  <= 1'b0;
          if (misaligned(req_addr[OFF_W-1:0], req_size)) begin
            rsp_ok  <= 1'b0;
            rsp_err <= 1'b1;
            st      <= S_RSP;
          end else if (amo_op_e'(req_op) == OP_STORE) begin
            st <= S_WR;
          end else begin
            st <= S_RD;
          end
        end
        S_RD: if (mem_gnt) st <= locked ? S_LWR : S_LD;
        S_LD: begin
          tmp <= old_lwr;
          if (op == OP_LOAD) begin
            rsp_data <= old_lwr;
            st       <= S_RSP;
          end else begin
            st <= S_OP;
          end
        end
        S_OP: begin
          rsp_data <= tmp;
          rsp_ok   <= (op != OP_CAS) || cas_hit;
          if (need_wr) begin
            wval <= newv;
            st   <= S_WR;
          end else begin
            st <= S_RSP;
          end
        end
        S_WR: if (mem_gnt) st <= S_RSP;
        S_LWR: if (mem_gnt) begin
          rsp_data <= old_lwr;
          rsp_ok   <= (op != OP_CAS) || cas_hit;
          st       <= S_RSP;
        end
        S_RSP: if (rsp_ready) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/amo_rmw_unit.sv
module amo_rmw_unit import amo_pkg::*; #(
  parameter int N_REQ  = 2,
  parameter int ADDR_W = 7,
  localparam int IDX_W = ADDR_W - OFF_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N_REQ-1:0]         req_valid,
  output logic [N_REQ-1:0]         req_ready,
  input  logic [2*N_REQ-1:0]       req_op,
  input  logic [2*N_REQ-1:0]       req_size,
  input  logic [N_REQ-1:0]         req_lock,
  input  logic [ADDR_W*N_REQ-1:0]  req_addr,
  input  logic [LINE_W*N_REQ-1:0]  req_wdata,
  input  logic [LINE_W*N_REQ-1:0]  req_cmp,
  output logic [N_REQ-1:0]         rsp_valid,
  input  logic [N_REQ-1:0]         rsp_ready,
  output logic [LINE_W*N_REQ-1:0]  rsp_data,
  output logic [N_REQ-1:0]         rsp_ok,
  output logic [N_REQ-1:0]         rsp_err
);
  logic [N_REQ-1:0]  mreq, mhold, mlockrd, gnt, we_v;
  logic [IDX_W-1:0]  idx_a [N_REQ];
  logic [LINE_W-1:0] wl_a  [N_REQ];
  logic [LANES-1:0]  be_a  [N_REQ];

  logic              m_en, m_we;
  logic [IDX_W-1:0]  m_idx;
  logic [LINE_W-1:0] m_wl, m_rd;
  logic [LANES-1:0]  m_be;

  for (genvar g = 0; g < N_REQ; g++) begin : g_agent
    amo_agent #(.ADDR_W(ADDR_W)) u_agent (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid[g]),
      .req_ready  (req_ready[g]),
      .req_op     (req_op[2*g +: 2]),
      .req_size   (req_size[2*g +: 2]),
      .req_lock   (req_lock[g]),
      .req_addr   (req_addr[ADDR_W*g +: ADDR_W]),
      .req_wdata  (req_wdata[LINE_W*g +: LINE_W]),
      .req_cmp    (req_cmp[LINE_W*g +: LINE_W]),
      .rsp_valid  (rsp_valid[g]),
      .rsp_ready  (rsp_ready[g]),
      .rsp_data   (rsp_data[LINE_W*g +: LINE_W]),
      .rsp_ok     (rsp_ok[g]),
      .rsp_err    (rsp_err[g]),
      .mem_req    (mreq[g]),
      .mem_hold   (mhold[g]),
      .mem_lockrd (mlockrd[g]),
      .mem_gnt    (gnt[g]),
      .mem_we     (we_v[g]),
      .mem_idx    (idx_a[g]),
      .mem_wline  (wl_a[g]),
      .mem_be     (be_a[g]),
      .mem_rdata  (m_rd)
    );
  end

  amo_arb #(.N(N_REQ)) u_arb (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (mreq),
    .hold  (mhold),
    .gnt   (gnt)
  );

  always_comb begin
    m_we  = 1'b0;
    m_idx = '0;
    m_wl  = '0;
    m_be  = '0;
    for (int i = 0; i < N_REQ; i++)
      if (gnt[i]) begin
        m_we  = we_v[i];
        m_idx = idx_a[i];
        m_wl  = wl_a[i];
        m_be  = be_a[i];
      end
  end
  assign m_en = |gnt;

  amo_mem #(.IDX_W(IDX_W)) u_mem (
    .clk   (clk),
    .en    (m_en),
    .we    (m_we),
    .idx   (m_idx),
    .wline (m_wl),
    .be    (m_be),
    .rdata (m_rd)
  );
endmodule

// File: rtl/amo_rmw_chk.sv
module amo_rmw_chk import amo_pkg::*; #(
  parameter int N_REQ = 2
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [N_REQ-1:0]        gnt,
  input logic [N_REQ-1:0]        mreq,
  input logic [N_REQ-1:0]        mlockrd,
  input logic [N_REQ-1:0]        req_valid,
  input logic [N_REQ-1:0]        req_ready,
  input logic [N_REQ-1:0]        rsp_valid,
  input logic [N_REQ-1:0]        rsp_ready,
  input logic [LINE_W*N_REQ-1:0] rsp_data
);
  a_r8_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));

  a_r8_grant_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt & ~mreq) == '0);

  a_r5_lock_keeps_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (|(gnt & mlockrd)) |=> (gnt == $past(gnt)));

  for (genvar g = 0; g < N_REQ; g++) begin : g_port
    a_r9_rsp_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid[g] && !rsp_ready[g]) |=>
        (rsp_valid[g] && $stable(rsp_data[LINE_W*g +: LINE_W])));

    a_r9_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid[g] && req_ready[g]) |=> !req_ready[g]);
  end
endmodule

bind amo_rmw_unit amo_rmw_chk #(.N_REQ(N_REQ)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .gnt       (gnt),
  .mreq      (mreq),
  .mlockrd   (mlockrd),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_data  (rsp_data)
);

// File: tb/sim_amo_rmw_unit.sv
`timescale 1ns/1ps
module sim_amo_rmw_unit;
  import amo_pkg::*;
  localparam int N = 2;
  localparam int AW = 7;
  localparam int NBYTES = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [N-1:0]        req_valid, req_ready, req_lock, rsp_valid, rsp_ready, rsp_ok, rsp_err;
  logic [2*N-1:0]      req_op, req_size;
  logic [AW*N-1:0]     req_addr;
  logic [LINE_W*N-1:0] req_wdata, req_cmp, rsp_data;

  logic        tv [N];
  logic        tl [N];
  logic        tr [N];
  logic [1:0]  to [N];
  logic [1:0]  ts [N];
  logic [AW-1:0] ta [N];
  logic [63:0] tw [N];
  logic [63:0] tc [N];
  logic [63:0] r_d [N];
  logic        r_ok [N];
  logic        r_err [N];

  assign req_valid = {tv[1], tv[0]};
  assign req_lock  = {tl[1], tl[0]};
  assign rsp_ready = {tr[1], tr[0]};
  assign req_op    = {to[1], to[0]};
  assign req_size  = {ts[1], ts[0]};
  assign req_addr  = {ta[1], ta[0]};
  assign req_wdata = {tw[1], tw[0]};
  assign req_cmp   = {tc[1], tc[0]};

  amo_rmw_unit #(.N_REQ(N), .ADDR_W(AW)) u0 (.*);

  int n_chk = 0, n_bad = 0;
  logic [7:0] mm [NBYTES];

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] msk(logic [1:0] sz);
    return (sz == 2'd3) ? '1 : ((64'd1 << (8 << sz)) - 64'd1);
  endfunction

  function automatic logic [63:0] m_get(int addr, logic [1:0] sz);
    logic [63:0] v = '0;
    for (int b = 0; b < (1 << sz); b++) v[b*8 +: 8] = mm[addr + b];
    return v;
  endfunction

  task automatic m_put(int addr, logic [1:0] sz, logic [63:0] v);
    for (int b = 0; b < (1 << sz); b++) mm[addr + b] = v[b*8 +: 8];
  endtask

  task automatic run_op(int a, logic [1:0] op, logic [1:0] sz, logic lk, int addr,
                        logic [63:0] wd, logic [63:0] cp);
    @(negedge clk);
    tv[a] = 1'b1; to[a] = op; ts[a] = sz; tl[a] = lk;
    ta[a] = AW'(addr); tw[a] = wd; tc[a] = cp;
    while (!req_ready[a]) @(negedge clk);
    @(negedge clk);
    tv[a] = 1'b0;
    while (!rsp_valid[a]) @(negedge clk);
    r_d[a] = rsp_data[64*a +: 64];
    r_ok[a] = rsp_ok[a];
    r_err[a] = rsp_err[a];
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [63:0] v, e;
    void'($urandom(32'd4242));
    for (int i = 0; i < N; i++) begin
      tv[i] = 0; tl[i] = 0; tr[i] = 1; to[i] = 0; ts[i] = 0; ta[i] = 0; tw[i] = 0; tc[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 req_ready after reset", 64'(req_ready), 64'b11);
    chk("R1 rsp_valid after reset", 64'(rsp_valid), 64'b00);

    for (int w = 0; w < NBYTES / 8; w++) begin
      v = {$urandom, $urandom};
      run_op(w % 2, 2'd1, 2'd3, 1'b0, w * 8, v, 64'd0);
      m_put(w * 8, 2'd3, v);
    end

    // random single-agent traffic against the byte model
    for (int it = 0; it < 400; it++) begin
      automatic int a = $urandom % 2;
      automatic logic [1:0] op = 2'($urandom);
      automatic logic [1:0] sz = 2'($urandom);
      automatic int off = ($urandom % 8) & ~((1 << sz) - 1);
      automatic int addr;
      automatic logic lk = 1'($urandom);
      automatic logic [63:0] wd = {$urandom, $urandom};
      automatic logic [63:0] cp;
      automatic logic [63:0] old;
      automatic logic bad_al;
      if ($urandom % 8 == 0) off = $urandom % 8;
      addr = ($urandom % (NBYTES / 8)) * 8 + off;
      bad_al = (off % (1 << sz)) != 0;
      old = bad_al ? 64'd0 : m_get(addr, sz);
      cp = ($urandom % 2) ? old : {$urandom, $urandom};
      run_op(a, op, sz, lk, addr, wd, cp);
      if (bad_al) begin
        chk("R7 random misaligned err", 64'(r_err[a]), 64'd1);
        chk("R7 random misaligned ok", 64'(r_ok[a]), 64'd0);
      end else begin
        chk("R7 random aligned no err", 64'(r_err[a]), 64'd0);
        case (op)
          2'd0: begin
            chk("R2 random load data", r_d[a], old);
            chk("R2 R10 random load ok", 64'(r_ok[a]), 64'd1);
          end
          2'd1: begin
            chk("R3 random store data", r_d[a], 64'd0);
            m_put(addr, sz, wd & msk(sz));
          end
          2'd2: begin
            chk("R4 random inc old", r_d[a], old);
            m_put(addr, sz, (old + 1) & msk(sz));
          end
          default: begin
            chk("R6 random cas data", r_d[a], old);
            chk("R6 random cas ok", 64'(r_ok[a]), 64'(old == (cp & msk(sz))));
            if (old == (cp & msk(sz))) m_put(addr, sz, wd & msk(sz));
          end
        endcase
      end
      if ($urandom % 4 == 0) begin
        run_op(1 - a, 2'd0, 2'd3, 1'($urandom), addr & ~7, 0, 0);
        chk("R3 random full line readback", r_d[1 - a], m_get(addr & ~7, 2'd3));
      end
    end

    // R3: byte store keeps neighbours
    run_op(0, 2'd1, 2'd3, 1'b0, 24, 64'h1122334455667788, 0);
    run_op(1, 2'd1, 2'd0, 1'b1, 29, 64'hFFFF_FFFF_FFFF_FFAB, 0);
    run_op(0, 2'd0, 2'd3, 1'b0, 24, 0, 0);
    chk("R3 byte store lane 5", r_d[0], 64'h1122AB4455667788);
    run_op(0, 2'd0, 2'd1, 1'b0, 30, 0, 0);
    chk("R2 halfword load lane 6", r_d[0], 64'h1122);
    m_put(24, 2'd3, 64'h1122AB4455667788);

    // R4: byte increment wraps within its lane
    run_op(0, 2'd1, 2'd0, 1'b0, 26, 64'hFF, 0);
    run_op(0, 2'd2, 2'd0, 1'b0, 26, 0, 0);
    chk("R4 byte inc old", r_d[0], 64'hFF);
    run_op(1, 2'd0, 2'd3, 1'b0, 24, 0, 0);
    chk("R4 byte inc wraps, neighbours kept", r_d[1], 64'h1122AB4455007788);
    m_put(24, 2'd3, 64'h1122AB4455007788);

    // R7: misaligned requests leave memory alone
    run_op(0, 2'd1, 2'd3, 1'b1, 28, 64'hDEAD, 0);
    chk("R7 misaligned double err", 64'(r_err[0]), 64'd1);
    chk("R7 misaligned double data", r_d[0], 64'd0);
    run_op(1, 2'd2, 2'd2, 1'b0, 26, 0, 0);
    chk("R7 misaligned word err", 64'(r_err[1]), 64'd1);
    run_op(0, 2'd3, 2'd1, 1'b1, 25, 64'h5, 64'h0);
    chk("R7 misaligned half err", 64'(r_err[0]), 64'd1);
    run_op(0, 2'd0, 2'd3, 1'b0, 24, 0, 0);
    chk("R7 memory unchanged", r_d[0], 64'h1122AB4455007788);

    // R6: compare-exchange hit then miss
    run_op(0, 2'd1, 2'd2, 1'b0, 40, 64'd5, 0);
    run_op(1, 2'd3, 2'd2, 1'b1, 40, 64'd9, 64'd5);
    chk("R6 cas hit ok", 64'(r_ok[1]), 64'd1);
    chk("R6 cas hit data", r_d[1], 64'd5);
    run_op(0, 2'd3, 2'd2, 1'b0, 40, 64'd7, 64'd5);
    chk("R6 cas miss ok", 64'(r_ok[0]), 64'd0);
    chk("R6 cas miss returns current", r_d[0], 64'd9);
    run_op(1, 2'd0, 2'd2, 1'b0, 40, 0, 0);
    chk("R6 cas miss leaves memory", r_d[1], 64'd9);

    // R4: two unlocked increments race -> one update lost
    v = m_get(48, 2'd2);
    fork
      run_op(0, 2'd2, 2'd2, 1'b0, 48, 0, 0);
      run_op(1, 2'd2, 2'd2, 1'b0, 48, 0, 0);
    join
    chk("R4 race agent0 old", r_d[0], v);
    chk("R4 race agent1 old", r_d[1], v);
    run_op(0, 2'd0, 2'd2, 1'b0, 48, 0, 0);
    e = (v + 1) & msk(2'd2);
    chk("R4 lost update final", r_d[0], e);

    // R5 R8: locked increments race after reset -> agent 0 first
    do_reset();
    v = e;
    fork
      run_op(0, 2'd2, 2'd2, 1'b1, 48, 0, 0);
      run_op(1, 2'd2, 2'd2, 1'b1, 48, 0, 0);
    join
    chk("R5 R8 locked race agent0 first", r_d[0], v);
    chk("R5 locked race agent1 sees update", r_d[1], (v + 1) & msk(2'd2));
    run_op(0, 2'd0, 2'd2, 1'b1, 48, 0, 0);
    chk("R5 locked final +2", r_d[0], (v + 2) & msk(2'd2));
    e = (v + 2) & msk(2'd2);

    // R8: agent0 was granted last, so agent1 wins the next race
    fork
      run_op(0, 2'd3, 2'd2, 1'b1, 48, 64'hA0, e);
      run_op(1, 2'd3, 2'd2, 1'b1, 48, 64'hB1, e);
    join
    chk("R8 rotation agent1 wins cas", 64'(r_ok[1]), 64'd1);
    chk("R6 R8 loser cas fails", 64'(r_ok[0]), 64'd0);
    chk("R6 loser sees winner value", r_d[0], 64'hB1);

    // R9: response held under back-pressure
    tr[0] = 1'b0;
    @(negedge clk);
    tv[0] = 1'b1; to[0] = 2'd0; ts[0] = 2'd2; tl[0] = 1'b0; ta[0] = AW'(48);
    while (!req_ready[0]) @(negedge clk);
    @(negedge clk);
    tv[0] = 1'b0;
    while (!rsp_valid[0]) @(negedge clk);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R9 rsp held valid", 64'(rsp_valid[0]), 64'd1);
      chk("R9 rsp held data", rsp_data[63:0], 64'hB1);
      chk("R9 no new request accepted", 64'(req_ready[0]), 64'd0);
    end
    tr[0] = 1'b1;
    @(negedge clk);
    chk("R9 rsp released", 64'(rsp_valid[0]), 64'd0);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule